// File: doc/BRIEF.md
# Packed Single-Precision Reciprocal Estimator

This unit returns a fast, reduced-precision estimate of 1/x for an IEEE-754 single-precision value. The operand arrives on a 64-bit packed bus. Only the low 32-bit lane is read, and the 32-bit estimate is copied into both lanes of the 64-bit result. It is meant to seed a later refinement step, so it trades exact division for a small table and one multiply.

The sign passes straight through. The exponent is reflected about the bias. The mantissa reciprocal comes from a table of 2^IDX_W + 1 entries computed at elaboration, indexed by the top mantissa bits and linearly interpolated on the remaining bits. Zeros, denormals, infinities, NaNs and magnitudes too large to have a normal reciprocal are each mapped to a fixed class of result. The unit has no status outputs.

Operands are accepted on a valid strobe. Each accepted operand yields a result after STAGES clock cycles (1 or 2), marked by a one-cycle output valid.

Top module: `rcp_est_unit`

## Requirements
- R1: While reset is asserted, and until the first result, valid_o is low and dst_o is all zeros.
- R2: valid_o is high for exactly one cycle, STAGES rising edges after the edge that samples valid_i high, and is low otherwise.
- R3: dst_o changes only on an edge that raises valid_o. While valid_o is low, dst_o holds the last result, whatever src_i does.
- R4: src_i[63:32] has no effect on the result. Only src_i[31:0] is interpreted (bit 31 sign, bits 30:23 biased exponent, bits 22:0 fraction).
- R5: dst_o[63:32] always equals dst_o[31:0].
- R6: For a finite normal input with biased exponent 1 to 252, the result has the input's sign, and |result * x - 1| < 2^-14.
- R7: For a normal input with biased exponent e in 1..252 and fraction zero, the result is exact: exponent field 254 - e and fraction zero.
- R8: For a normal input with biased exponent e in 1..252 and a nonzero fraction, the result exponent field is 253 - e.
- R9: A finite input with biased exponent 253 or 254 (magnitude at least 2^126) gives a zero with the input's sign (0x00000000 or 0x80000000).
- R10: An input with biased exponent 0 (zero or denormal) gives an infinity with the input's sign (exponent 0xFF, fraction 0).
- R11: An infinite input (exponent 0xFF, fraction 0) gives a zero with the input's sign.
- R12: A NaN input (exponent 0xFF, fraction nonzero) gives a quiet NaN: the sign and fraction are kept, fraction bit 22 is forced to 1, and the exponent is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand strobe |
| src_i | input | 64 | Packed operand; low lane is interpreted |
| valid_o | output | 1 | Result strobe |
| dst_o | output | 64 | Estimate copied into both 32-bit lanes |

## Verification
The bench builds the unit with IDX_W = 7 and STAGES = 2. The two-deep pipeline brings within reach the early-valid check and the rule that results hold across idle cycles when more than one register sits between input and output. A 7-bit index leaves the interpolation error near 2^-16 at mantissas close to 1, where the error bound is tightest. Directed cases are run at that limit and at every class boundary: exponent 252 against 253, the smallest normal, and signalling against quiet NaNs. Several hundred random normal operands are also checked against a real-valued reciprocal.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;

  localparam logic [EXP_W-1:0] EXP_ALL1  = '1;
  localparam logic [EXP_W-1:0] EXP_HUGE  = 8'd253;  // |x| >= 2^126
  localparam logic [EXP_W-1:0] EXP_UNIT  = 8'd254;
  localparam logic [EXP_W-1:0] EXP_FRACT = 8'd253;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  exp;
    logic [FRAC_W-1:0] frac;
  } fp32_t;

  typedef enum logic [2:0] {
    CLS_NORM,
    CLS_NAN,
    CLS_INF,
    CLS_TINY,
    CLS_HUGE
  } rcp_cls_e;
endpackage

// File: rtl/rcp_classify.sv
module rcp_classify
  import rcp_pkg::*;
(
  input  fp32_t    op_i,
  output rcp_cls_e cls_o
);
  logic frac_nz;
  assign frac_nz = |op_i.frac;

  always_comb begin
    if (op_i.exp == EXP_ALL1)      cls_o = frac_nz ? CLS_NAN : CLS_INF;
    else if (op_i.exp == '0)       cls_o = CLS_TINY;
    else if (op_i.exp >= EXP_HUGE) cls_o = CLS_HUGE;
    else                           cls_o = CLS_NORM;
  end
endmodule

// File: rtl/rcp_mant_est.sv
module rcp_mant_est
  import rcp_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic [FRAC_W-1:0] frac_i,
  output logic [FRAC_W-1:0] frac_o,
  output logic              unit_o
);
  localparam int unsigned TAIL_W = FRAC_W - IDX_W;
  localparam int unsigned PREC   = FRAC_W + 1;       // table fraction bits
  localparam int unsigned ENT_W  = PREC + 1;         // holds 1.0 exactly
  localparam int unsigned TBL_N  = 1 << IDX_W;
  localparam int unsigned ACC_W  = ENT_W + TAIL_W;

  // round(2^PREC / (1 + i/TBL_N))
  function automatic logic [ENT_W-1:0] rcp_entry(input int unsigned i);
    longint unsigned num, den;
    num = longint'(1) << (PREC + IDX_W);
    den = longint'(TBL_N) + longint'(i);
    return ENT_W'((num + den / 2) / den);
  endfunction

  logic [ENT_W-1:0] lut [TBL_N+1];

  for (genvar g = 0; g <= TBL_N; g++) begin : g_lut
    localparam logic [ENT_W-1:0] ENT_V = rcp_entry(g);
    assign lut[g] = ENT_V;
  end

  logic [IDX_W-1:0]  idx;
  logic [IDX_W:0]    idx_n;
  logic [TAIL_W-1:0] tail;
  logic [ENT_W-1:0]  base, nxt, diff;
  logic [ACC_W-1:0]  prod, est_ext;
  logic              grd, stk, lsb, rnd;
  logic [ENT_W-1:0]  est;

  assign idx   = frac_i[FRAC_W-1 -: IDX_W];
  assign idx_n = {1'b0, idx} + (IDX_W+1)'(1);
  assign tail  = frac_i[TAIL_W-1:0];

  assign base = lut[idx];
  assign nxt  = lut[idx_n];
  assign diff = base - nxt;

  // base - diff * tail / 2^TAIL_W, kept at full width for rounding
  assign prod    = ACC_W'(diff) * ACC_W'(tail);
  assign est_ext = {base, {TAIL_W{1'b0}}} - prod;

  assign grd = est_ext[TAIL_W-1];
  assign stk = |est_ext[TAIL_W-2:0];
  assign lsb = est_ext[TAIL_W];
  assign rnd = grd & (stk | lsb);
  assign est = est_ext[ACC_W-1:TAIL_W] + ENT_W'(rnd);

  // est == 2^PREC only for a unit mantissa; otherwise est in (2^(PREC-1), 2^PREC)
  assign unit_o = est[ENT_W-1];
  assign frac_o = est[ENT_W-1] ? est[ENT_W-2:1] : est[FRAC_W-1:0];
endmodule

// File: rtl/rcp_assemble.sv
module rcp_assemble
  import rcp_pkg::*;
(
  input  fp32_t             op_i,
  input  rcp_cls_e          cls_i,
  input  logic [FRAC_W-1:0] est_frac_i,
  input  logic              est_unit_i,
  output logic [WORD_W-1:0] res_o
);
  localparam logic [FRAC_W-1:0] QUIET_BIT = FRAC_W'(1) << (FRAC_W - 1);

  logic [EXP_W-1:0] exp_r;
  assign exp_r = (est_unit_i ? EXP_UNIT : EXP_FRACT) - op_i.exp;

  always_comb begin
    unique case (cls_i)
      CLS_NAN:  res_o = {op_i.sign, EXP_ALL1, op_i.frac | QUIET_BIT};
      CLS_TINY: res_o = {op_i.sign, EXP_ALL1, {FRAC_W{1'b0}}};
      CLS_INF,
      CLS_HUGE: res_o = {op_i.sign, {(WORD_W-1){1'b0}}};
      default:  res_o = {op_i.sign, exp_r, est_frac_i};
    endcase
  end
endmodule

// File: rtl/rcp_est_unit.sv
module rcp_est_unit
  import rcp_pkg::*;
#(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned STAGES = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic [2*WORD_W-1:0] src_i,
  output logic                valid_o,
  output logic [2*WORD_W-1:0] dst_o
);
  fp32_t             op;
  rcp_cls_e          cls;
  logic [FRAC_W-1:0] est_frac;
  logic              est_unit;
  logic [WORD_W-1:0] res;
  logic              unused_hi;

  assign op        = fp32_t'(src_i[WORD_W-1:0]);
  assign unused_hi = ^src_i[2*WORD_W-1:WORD_W];

  rcp_classify u_cls (
    .op_i  (op),
    .cls_o (cls)
  );

  rcp_mant_est #(.IDX_W(IDX_W)) u_mant (
    .frac_i (op.frac),
    .frac_o (est_frac),
    .unit_o (est_unit)
  );

  rcp_assemble u_asm (
    .op_i       (op),
    .cls_i      (cls),
    .est_frac_i (est_frac),
    .est_unit_i (est_unit),
    .res_o      (res)
  );

  logic [STAGES-1:0]             vld_q;
  logic [STAGES-1:0][WORD_W-1:0] dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      dat_q <= '0;
    end else begin
      vld_q[0] <= valid_i;
      if (valid_i) dat_q[0] <= res;
      for (int s = 1; s < STAGES; s++) begin
        vld_q[s] <= vld_q[s-1];
        if (vld_q[s-1]) dat_q[s] <= dat_q[s-1];
      end
    end
  end

  assign valid_o = vld_q[STAGES-1];
  assign dst_o   = {dat_q[STAGES-1], dat_q[STAGES-1]};
endmodule

// File: rtl/rcp_est_unit_chk.sv
module rcp_est_unit_chk #(
  parameter int unsigned STAGES = 1
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [63:0] src_i,
  input logic        valid_o,
  input logic [63:0] dst_o
);
  logic [STAGES-1:0]       v_sh;
  logic [STAGES-1:0][31:0] x_sh;
  logic                    unused_hi;
  logic [31:0]             cap;
  logic [7:0]              ce;
  logic                    c_fz;

  assign unused_hi = ^src_i[63:32];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_sh <= '0;
      x_sh <= '0;
    end else begin
      v_sh[0] <= valid_i;
      if (valid_i) x_sh[0] <= src_i[31:0];
      for (int s = 1; s < STAGES; s++) begin
        v_sh[s] <= v_sh[s-1];
        if (v_sh[s-1]) x_sh[s] <= x_sh[s-1];
      end
    end
  end

  assign cap  = x_sh[STAGES-1];
  assign ce   = cap[30:23];
  assign c_fz = (cap[22:0] == 23'h0);

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_sh[STAGES-1]);

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(dst_o));

  p_lanes_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dst_o[63:32] == dst_o[31:0]);

  p_sign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> dst_o[31] == cap[31]);

  p_unit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ce != 8'd0 && ce < 8'd253 && c_fz)
      |-> (dst_o[30:23] == 8'd254 - ce) && (dst_o[22:0] == 23'h0));

  p_exp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ce != 8'd0 && ce < 8'd253 && !c_fz)
      |-> dst_o[30:23] == 8'd253 - ce);

  p_huge_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (ce == 8'd253 || ce == 8'd254)) |-> dst_o[30:0] == 31'h0);

  p_tiny_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ce == 8'd0) |-> dst_o[30:0] == {8'hFF, 23'h0});

  p_inf_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ce == 8'hFF && c_fz) |-> dst_o[30:0] == 31'h0);

  p_nan_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ce == 8'hFF && !c_fz)
      |-> dst_o[30:0] == {8'hFF, cap[22:0] | 23'h40_0000});
endmodule

bind rcp_est_unit rcp_est_unit_chk #(.STAGES(STAGES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .src_i   (src_i),
  .valid_o (valid_o),
  .dst_o   (dst_o)
);

// File: tb/rcp_est_unit_tb.sv
`timescale 1ns/1ps
module rcp_est_unit_tb;
  localparam int unsigned TB_IDX_W  = 7;
  localparam int unsigned TB_STAGES = 2;
  localparam real         ERR_LIM   = 1.0 / 16384.0;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        valid_i;
  logic [63:0] src_i;
  logic        valid_o;
  logic [63:0] dst_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  rcp_est_unit #(.IDX_W(TB_IDX_W), .STAGES(TB_STAGES)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .src_i   (src_i),
    .valid_o (valid_o),
    .dst_o   (dst_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic real fp_val(input logic [31:0] b);
    real m, p;
    int  e;
    m = 1.0 + real'(b[22:0]) / 8388608.0;
    e = int'(b[30:23]) - 127;
    p = 1.0;
    if (e >= 0) for (int k = 0; k < e; k++) p = p * 2.0;
    else        for (int k = 0; k < -e; k++) p = p / 2.0;
    return b[31] ? -(m * p) : (m * p);
  endfunction

  function automatic logic [31:0] next_rand(input logic [31:0] l);
    logic [31:0] t;
    t = l;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // drive one operand, sample after the pipeline (R2, R5 on every op)
  task automatic run_op(input logic [63:0] s, output logic [31:0] res);
    @(negedge clk);
    valid_i = 1'b1;
    src_i   = s;
    @(negedge clk);
    valid_i = 1'b0;
    if (TB_STAGES > 1) chk(valid_o == 1'b0, "R2 early valid", 64'(valid_o), 64'd0);
    repeat (TB_STAGES - 1) @(negedge clk);
    chk(valid_o == 1'b1, "R2 valid at latency", 64'(valid_o), 64'd1);
    chk(dst_o[63:32] == dst_o[31:0], "R5 lane copy", 64'(dst_o[63:32]), 64'(dst_o[31:0]));
    res = dst_o[31:0];
  endtask

  task automatic chk_normal(input logic [31:0] x, input logic [31:0] r);
    real pr, err;
    pr  = fp_val(x) * fp_val(r);
    err = pr - 1.0;
    if (err < 0.0) err = -err;
    n_chk++;
    if (!(err < ERR_LIM)) begin
      n_bad++;
      $display("FAIL R6 x=%h res=%h err=%g limit=%g", x, r, err, ERR_LIM);
    end
    chk(r[31] == x[31], "R6 sign", 64'(r[31]), 64'(x[31]));
    if (x[22:0] == 23'h0)
      chk(r == {x[31], 8'd254 - x[30:23], 23'h0}, "R7 exact power of two",
          64'(r), 64'({x[31], 8'd254 - x[30:23], 23'h0}));
    else
      chk(r[30:23] == 8'd253 - x[30:23], "R8 exponent", 64'(r[30:23]), 64'(8'd253 - x[30:23]));
  endtask

  task automatic t_reset();
    chk(valid_o == 1'b0, "R1 valid in reset", 64'(valid_o), 64'd0);
    chk(dst_o == 64'h0, "R1 data in reset", dst_o, 64'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(valid_o == 1'b0 && dst_o == 64'h0, "R1 idle after reset", dst_o, 64'h0);
  endtask

  task automatic t_pow2();
    logic [31:0] r;
    logic [7:0]  ev [5] = '{8'd1, 8'd100, 8'd127, 8'd200, 8'd252};
    foreach (ev[k]) begin
      logic [31:0] x;
      x = {k[0], ev[k], 23'h0};
      run_op({32'h0, x}, r);
      chk(r == {x[31], 8'd254 - ev[k], 23'h0}, "R7 unit mantissa", 64'(r),
          64'({x[31], 8'd254 - ev[k], 23'h0}));
    end
  endtask

  task automatic t_directed();
    logic [31:0] r;
    logic [31:0] xs [7] = '{32'h3FC0_0000, 32'h4040_0000, 32'h3F80_0001, 32'h3FFF_FFFF,
                            32'h7E7F_FFFF, 32'h8080_0001, 32'hC2F6_E979};
    foreach (xs[k]) begin
      run_op({32'h0, xs[k]}, r);
      chk_normal(xs[k], r);
    end
  endtask

  task automatic t_random();
    logic [31:0] r;
    for (int k = 0; k < 300; k++) begin
      logic [31:0] x;
      logic [7:0]  e;
      lfsr = next_rand(lfsr);
      e    = 8'(1 + (int'(lfsr[30:23]) % 252));
      x    = {lfsr[31], e, lfsr[22:0]};
      run_op({lfsr ^ 32'hA5A5_5A5A, x}, r);
      chk_normal(x, r);
    end
  endtask

  task automatic t_specials();
    logic [31:0] r;
    logic [31:0] xin [13] = '{32'h0000_0000, 32'h8000_0000, 32'h0000_0001, 32'h8040_0000,
                              32'h7F80_0000, 32'hFF80_0000, 32'h7FC0_0001, 32'h7F80_0005,
                              32'hFF80_0001, 32'h7E80_0000, 32'hFF7F_FFFF, 32'h7F00_0000,
                              32'h807F_FFFF};
    logic [31:0] xex [13] = '{32'h7F80_0000, 32'hFF80_0000, 32'h7F80_0000, 32'hFF80_0000,
                              32'h0000_0000, 32'h8000_0000, 32'h7FC0_0001, 32'h7FC0_0005,
                              32'hFFC0_0001, 32'h0000_0000, 32'h8000_0000, 32'h0000_0000,
                              32'hFF80_0000};
    string tg [13] = '{"R10 +zero", "R10 -zero", "R10 denormal", "R10 -denormal",
                       "R11 +inf", "R11 -inf", "R12 quiet nan", "R12 signalling nan",
                       "R12 -nan", "R9 2^126", "R9 -max", "R9 exp 254", "R10 max denormal"};
    foreach (xin[k]) begin
      run_op({32'h0, xin[k]}, r);
      chk(r == xex[k], tg[k], 64'(r), 64'(xex[k]));
    end
    // smallest normal: 1/2^-126 = 2^126, still representable
    run_op({32'h0, 32'h0080_0000}, r);
    chk(r == 32'h7E80_0000, "R7 smallest normal", 64'(r), 64'h7E80_0000);
  endtask

  task automatic t_upper_lane();
    logic [31:0] r0, r1, r2;
    run_op({32'h0000_0000, 32'h3FAB_CDEF}, r0);
    run_op({32'h7FC0_0000, 32'h3FAB_CDEF}, r1);
    run_op({32'hFFFF_FFFF, 32'h3FAB_CDEF}, r2);
    chk(r1 == r0, "R4 upper lane nan", 64'(r1), 64'(r0));
    chk(r2 == r0, "R4 upper lane ones", 64'(r2), 64'(r0));
  endtask

  task automatic t_hold();
    logic [31:0] r;
    logic [63:0] held;
    run_op({32'h0, 32'h4120_0000}, r);
    held = dst_o;
    for (int k = 0; k < 6; k++) begin
      lfsr  = next_rand(lfsr);
      src_i = {lfsr, ~lfsr};
      @(negedge clk);
      chk(valid_o == 1'b0, "R2 single-cycle valid", 64'(valid_o), 64'd0);
      chk(dst_o == held, "R3 hold while idle", dst_o, held);
    end
  endtask

  initial begin
    rst_ni  = 1'b0;
    valid_i = 1'b0;
    src_i   = 64'h0;
    repeat (3) @(negedge clk);
    t_reset();
    t_pow2();
    t_directed();
    t_specials();
    t_upper_lane();
    t_hold();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", 64'd0, 64'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule